// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial front end of a small non-volatile memory. It gathers write data into a four-byte page buffer and then programs the whole page into a 128 x 8 storage array as one self-timed operation. The front end first presents a start address. It then presents one strobe per received data byte, and finally a one-cycle pulse when the bus transaction ends.

The low two address bits select a slot in the buffer and advance after every accepted byte. They wrap inside the page, so a fifth byte lands where the first one went. The upper five bits pick the page and never change during a transaction. When the end-of-transaction pulse arrives and at least one byte was collected, the block issues a single page write to the array. A per-byte mask travels with that write so that slots left unwritten keep their old array contents. A counter then holds the block busy for a fixed number of clock cycles to model the programming time. While the block is busy it ignores every input.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy`, `arr_we` and `arr_wmask` are all low, and every byte lane of `arr_wdata` is zero.
- R2: When the block is idle, an accepted `addr_load` takes `addr_in[6:2]` as the page and `addr_in[1:0]` as the slot pointer. The page shows on `arr_page` from the next cycle. The load also clears `arr_wmask`.
- R3: When the block is idle, an accepted `byte_vld` stores `byte_data` in lane p of the buffer, where p is the current pointer. Lane p is `arr_wdata[8p+7:8p]`. The same byte sets `arr_wmask[p]`, and the pointer becomes (p+1) mod 4 while the page stays the same. A lane keeps its contents until it is written again.
- R4: When more than four bytes arrive before the end pulse, the pointer wraps and the later bytes overwrite the lanes that were written earlier. Only the last byte written to each lane is committed.
- R5: A `stop` pulse that is accepted while idle with a non-zero mask raises `arr_we` for exactly one cycle, in the next cycle. During that cycle `arr_page`, `arr_wmask` and `arr_wdata` carry the collected page.
- R6: `busy` rises in the same cycle as `arr_we` and stays high for exactly PROG_CYCLES cycles.
- R7: While `busy` is high, `addr_load`, `byte_vld` and `stop` have no effect. The page, the pointer and the buffer contents are left unchanged.
- R8: When `busy` falls, `arr_wmask` is zero.
- R9: A `stop` pulse with an empty mask raises neither `busy` nor `arr_we`.
- R10: In the same cycle, `stop` takes priority over `addr_load` and `byte_vld`, which are then dropped. `addr_load` takes priority over `byte_vld`, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Start-address strobe |
| addr_in | input | 7 | Start address: page in [6:2], slot in [1:0] |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | End-of-transaction pulse |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | One-cycle page write strobe to the array |
| arr_page | output | 5 | Page index of the write |
| arr_wmask | output | 4 | Per-lane valid mask of the buffer |
| arr_wdata | output | 32 | Buffer contents, lane i in bits [8i+7:8i] |

## Verification
The assertions check on every cycle the properties that hold across the whole commit sequence. The write strobe lasts one cycle and coincides with the rise of busy. No commit is ever issued with an empty mask. The busy window has exactly the programmed length, the mask is clear when busy falls, and the page and data outputs are frozen while busy. Other behaviour can only be shown by the bench's scenarios, because it depends on the bytes sent earlier. That covers which lane each byte lands in, how the pointer wraps and overwrites, that junk input during busy changes nothing afterwards, and the same-cycle priority between the end pulse, the address load and the byte strobe.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [0:0] {
    PG_IDLE = 1'b0,
    PG_PROG = 1'b1
  } pg_state_e;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl #(
  parameter int PROG_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic any_vld_i,
  output logic busy_o,
  output logic commit_o,
  output logic we_o,
  output logic done_o
);
  import pgbuf_pkg::*;

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  pg_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             we_q, we_d;

  assign commit_o = (state_q == PG_IDLE) && stop_i && any_vld_i;
  assign done_o   = (state_q == PG_PROG) && (cnt_q == '0);
  assign cnt_en   = commit_o || (state_q == PG_PROG);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    we_d    = 1'b0;
    case (state_q)
      PG_IDLE: begin
        if (commit_o) begin
          state_d = PG_PROG;
          cnt_d   = CNT_W'(PROG_CYCLES - 1);
          we_d    = 1'b1;
        end
      end
      PG_PROG: begin
        if (cnt_q == '0) state_d = PG_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (state_q == PG_PROG);
  assign we_o   = we_q;
endmodule

// File: rtl/pgbuf_addr.sv
module pgbuf_addr #(
  parameter int ADDR_W = 7,
  parameter int PTR_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adv_i,
  output logic [ADDR_W-PTR_W-1:0] page_o,
  output logic [PTR_W-1:0]        ptr_o
);
  localparam int PAGE_W = ADDR_W - PTR_W;

  logic [PAGE_W-1:0] page_q, page_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              ptr_en;

  assign ptr_en = load_i || adv_i;

  always_comb begin
    page_d = page_q;
    ptr_d  = ptr_q;
    if (load_i) begin
      page_d = addr_i[ADDR_W-1:PTR_W];
      ptr_d  = addr_i[PTR_W-1:0];
    end else if (adv_i) begin
      ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= '0;
    else if (load_i) page_q <= page_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign page_o = page_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/pgbuf_lane.sv
module pgbuf_lane #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              v_o
);
  logic [DATA_W-1:0] q_q;
  logic              v_q, v_d, v_en;

  assign v_en = wr_i || clr_i;

  always_comb begin
    v_d = v_q;
    if (clr_i)     v_d = 1'b0;
    else if (wr_i) v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (wr_i) q_q <= d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_q <= 1'b0;
    else if (v_en) v_q <= v_d;
  end

  assign q_o = q_q;
  assign v_o = v_q;
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int LANES       = 4,
  parameter int PROG_CYCLES = 20,
  localparam int PTR_W      = $clog2(LANES),
  localparam int PAGE_W     = ADDR_W - PTR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addr_load,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    byte_vld,
  input  logic [DATA_W-1:0]       byte_data,
  input  logic                    stop,
  output logic                    busy,
  output logic                    arr_we,
  output logic [PAGE_W-1:0]       arr_page,
  output logic [LANES-1:0]        arr_wmask,
  output logic [LANES*DATA_W-1:0] arr_wdata
);
  logic             busy_w, commit_w, done_w, we_w;
  logic             idle, load_en, byte_en, clr_en;
  logic [PTR_W-1:0] ptr_w;
  logic [LANES-1:0] vld_w;

  assign idle    = !busy_w;
  assign load_en = idle && addr_load && !stop;
  assign byte_en = idle && byte_vld && !stop && !addr_load;
  assign clr_en  = done_w || load_en;

  pgbuf_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop),
    .any_vld_i (|vld_w),
    .busy_o    (busy_w),
    .commit_o  (commit_w),
    .we_o      (we_w),
    .done_o    (done_w)
  );

  pgbuf_addr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_en),
    .addr_i (addr_in),
    .adv_i  (byte_en),
    .page_o (arr_page),
    .ptr_o  (ptr_w)
  );

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic lane_wr;
    assign lane_wr = byte_en && (ptr_w == PTR_W'(gi));
    pgbuf_lane #(.DATA_W(DATA_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (lane_wr),
      .clr_i (clr_en),
      .d_i   (byte_data),
      .q_o   (arr_wdata[gi*DATA_W +: DATA_W]),
      .v_o   (vld_w[gi])
    );
  end

  assign busy      = busy_w;
  assign arr_we    = we_w;
  assign arr_wmask = vld_w;

  logic unused_commit;
  assign unused_commit = commit_w;
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
  parameter int PROG_CYCLES = 20,
  parameter int PAGE_W      = 5,
  parameter int LANES       = 4,
  parameter int DATA_W      = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stop,
  input logic                    busy,
  input logic                    arr_we,
  input logic [PAGE_W-1:0]       arr_page,
  input logic [LANES-1:0]        arr_wmask,
  input logic [LANES*DATA_W-1:0] arr_wdata
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we); // R5
  AST_WE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wmask != '0)); // R5
  AST_WE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> arr_we); // R6
  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == PROG_CYCLES)); // R6
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(arr_page) && $stable(arr_wdata))); // R7
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (arr_wmask == '0)); // R8
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop && arr_wmask == '0) |=> (!busy && !arr_we)); // R9
  AST_STOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop && arr_wmask != '0) |=> (busy && arr_we)); // R5
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
  .PROG_CYCLES(PROG_CYCLES), .PAGE_W(PAGE_W), .LANES(LANES), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop      (stop),
  .busy      (busy),
  .arr_we    (arr_we),
  .arr_page  (arr_page),
  .arr_wmask (arr_wmask),
  .arr_wdata (arr_wdata)
);

// File: tb/pgbuf_commit_bench.sv
module pgbuf_commit_bench;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_load = 1'b0;
  logic [6:0]  addr_in = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        stop = 1'b0;
  logic        busy, arr_we;
  logic [4:0]  arr_page;
  logic [3:0]  arr_wmask;
  logic [31:0] arr_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] m_data [4];
  logic [3:0] m_mask;
  logic [4:0] m_page;
  logic [1:0] m_ptr;

  always #2.5 clk = ~clk;

  pgbuf_commit #(.PROG_CYCLES(P)) u_pgbuf_commit (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .busy(busy),
    .arr_we(arr_we), .arr_page(arr_page), .arr_wmask(arr_wmask), .arr_wdata(arr_wdata)
  );

  function automatic logic [31:0] exp_word();
    return {m_data[3], m_data[2], m_data[1], m_data[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(arr_wmask == m_mask, req, "mask", arr_wmask, m_mask);
    chk(arr_wdata == exp_word(), req, "data", arr_wdata, exp_word());
    chk(arr_page == m_page, req, "page", arr_page, m_page);
  endtask

  task automatic do_load(input logic [6:0] a);
    addr_load = 1'b1; addr_in = a;
    @(negedge clk);
    addr_load = 1'b0;
    m_page = a[6:2]; m_ptr = a[1:0]; m_mask = '0;
    chk_state("R2");
  endtask

  task automatic do_byte(input logic [7:0] d, input string req);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
    m_data[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 2'd1;
    chk_state(req);
  endtask

  task automatic do_stop(input bit with_byte, input bit with_load);
    int n;
    logic [31:0] w;
    stop = 1'b1; byte_vld = with_byte; byte_data = 8'h5a;
    addr_load = with_load; addr_in = 7'h55;
    @(negedge clk);
    stop = 1'b0; byte_vld = 1'b0; addr_load = 1'b0;
    if (with_byte || with_load) chk_state("R10");
    if (m_mask == '0) begin
      chk(!busy && !arr_we, "R9", "busy/we after empty stop", {busy, arr_we}, 0);
      @(negedge clk);
      chk(!busy && !arr_we, "R9", "busy/we one cycle on", {busy, arr_we}, 0);
      return;
    end
    chk(arr_we, "R5", "write strobe", arr_we, 1);
    chk(busy, "R6", "busy with strobe", busy, 1);
    chk_state("R5");
    w = exp_word();
    n = 1;
    while (busy && n < P + 10) begin
      addr_load = 1'($urandom); addr_in = 7'($urandom);
      byte_vld = 1'($urandom); byte_data = 8'($urandom); stop = 1'($urandom);
      @(negedge clk);
      if (busy) n++;
      if (n == 2) chk(!arr_we, "R5", "strobe second cycle", arr_we, 0);
    end
    addr_load = 1'b0; byte_vld = 1'b0; stop = 1'b0;
    chk(n == P, "R6", "busy length", n, P);
    m_mask = '0;
    chk(arr_wmask == '0, "R8", "mask after release", arr_wmask, 0);
    chk(arr_wdata == w && arr_page == m_page, "R7", "state after busy junk",
        arr_wdata, w);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m_data[i] = '0;
    m_mask = '0; m_page = '0; m_ptr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !arr_we && arr_wmask == '0 && arr_wdata == '0, "R1", "reset",
        {busy, arr_we, arr_wmask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    do_stop(1'b0, 1'b0);
    do_load(7'd0);
    do_byte(8'h11, "R3");
    do_stop(1'b0, 1'b0);
    do_load(7'd127);
    do_byte(8'ha1, "R3");
    do_byte(8'ha2, "R3");
    chk(arr_page == 5'd31, "R3", "page fixed across wrap", arr_page, 31);
    do_stop(1'b0, 1'b0);
    do_load(7'd41);
    for (int k = 0; k < 6; k++) do_byte(8'(8'hc0 + k), "R4");
    do_stop(1'b0, 1'b0);
    do_byte(8'h77, "R7");
    do_stop(1'b1, 1'b0);
    do_load(7'd8);
    do_byte(8'h33, "R3");
    addr_load = 1'b1; addr_in = 7'd14; byte_vld = 1'b1; byte_data = 8'hee;
    @(negedge clk);
    addr_load = 1'b0; byte_vld = 1'b0;
    m_page = 5'd3; m_ptr = 2'd2; m_mask = '0;
    chk_state("R10");
    do_byte(8'h44, "R10");
    do_stop(1'b0, 1'b1);
    do_load(7'd20);
    do_stop(1'b0, 1'b0);

    for (int t = 0; t < 60; t++) begin
      int nb;
      if (($urandom % 6) != 0) do_load(7'($urandom));
      nb = int'($urandom % 8);
      for (int k = 0; k < nb; k++) do_byte(8'($urandom), nb > 4 ? "R4" : "R3");
      do_stop(($urandom % 5) == 0, ($urandom % 5) == 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule